// File: doc/BRIEF.md
# Programmable Counter/Timer Channel

This block is a single counter/timer channel with a 36-bit count register. On every count tick the register steps up or down by one. A tick comes either from the system clock or from rising edges on an external count line. In free-running mode the count wraps at its end value. In divide-by-N mode it counts down from a programmed period, reloads itself, and produces a periodic waveform on its output pin. That waveform is either a one-clock pulse or a square wave.

Software drives the channel through a small register bus. The bus holds a load value and a control word. A latch command copies the running count into a shadow register. The shadow can then be read at leisure while counting continues. The only event the channel exports is a terminal-count flag. Pin muxing and interrupt collection are left to the surrounding logic.

Top module: `ctr_timer_channel`

## Requirements
- R1: After reset the channel is disabled, and the count, load value, control word and shadow all read 0. The output pin and the terminal-count flag are low.
- R2: A write to address 0 while the channel is disabled sets the count, the active period and the load value to the written data on that clock edge.
- R3: With control bit 1 (up) set and divide mode off, each tick adds one to the count. A tick taken at the all-ones value is terminal and wraps the count to 0.
- R4: With bit 1 clear and divide mode off, each tick subtracts one from the count. A tick taken at 0 is terminal and wraps the count to all-ones.
- R5: With control bit 2 clear, every clock edge while enabled is a tick. With bit 2 set, only rising edges of the external count line are ticks: each rising edge is counted once, after a two-flop synchronizer and an edge detector, and the clock itself is not counted.
- R6: A write to address 2 copies the count as it stood before that edge into the shadow register. A read of address 2 returns the shadow, which stays unchanged until the next latch command while the count keeps running.
- R7: With control bit 3 (divide) set, the count steps down regardless of bit 1. A tick taken at a count of 1 or less is terminal and reloads the load value, so the period is N ticks.
- R8: A write to address 0 while enabled changes only the load value. The count and the active period take the new value at the next reload.
- R9: With control bit 4 clear (pulse shape), the output pin and the terminal-count flag are high for exactly the one clock that follows a terminal tick.
- R10: In divide mode with bit 4 set (square shape), the output is high while the count is above floor(N/2). This gives ceil(N/2) high ticks and floor(N/2) low ticks per period.
- R11: In free-running mode with bit 4 set, the output toggles on each terminal tick.
- R12: While control bit 0 (enable) is clear the count does not move. The output and the flag are low from the second edge after the disable write onwards.
- R13: The control word at address 1 holds bits [4:0] = {square, divide, external, up, enable} and reads back as written. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address (0 load, 1 control, 2 latch/shadow, 3 unused) |
| bus_wdata | input | 36 | Write data |
| bus_rdata | output | 36 | Read data for bus_addr, combinational |
| cnt_in | input | 1 | External count line, asynchronous |
| cnt_out | output | 1 | Channel output pin |
| tc_evt | output | 1 | One-clock terminal-count flag |

## Verification
Every internal register is observable at the ports. A wrong count or a wrong active period shows up as a wrong shadow value at the next latch command. In divide mode it also shows up as a pulse or square edge landing one or more clocks off the expected edge, within a single period. A wrong shadow or a wrong control word is visible on the very next read. The bench places every output check on a specific clock edge derived from the tick count, so a design that is off by one tick cannot pass.

// File: rtl/ctr_timer_channel.sv
module ctr_timer_channel #(
  parameter int CNT_W       = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  input  logic             cnt_in,
  output logic             cnt_out,
  output logic             tc_evt
);
  localparam int CTRL_W = 5;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CTRL_W-1:0]  ctrl_q;
  logic [CNT_W-1:0]   load_q, per_q, cnt_q, shadow_q;
  logic [SYNC_STAGES:0] sync_q;
  logic               out_q, tc_q;
  logic               en, up, src_ext, div_mode, square;
  logic               wr_load, wr_ctrl, wr_latch;
  logic               rise, tick, term, sq_hi;
  logic [CNT_W-1:0]   cnt_nxt, per_nxt;

  assign {square, div_mode, src_ext, up, en} = ctrl_q;

  assign wr_load  = bus_wr && (bus_addr == 2'd0);
  assign wr_ctrl  = bus_wr && (bus_addr == 2'd1);
  assign wr_latch = bus_wr && (bus_addr == 2'd2);

  assign rise = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
  assign tick = en & (src_ext ? rise : 1'b1);
  assign term = div_mode ? (cnt_q <= CNT_ONE)
                         : (up ? (cnt_q == CNT_MAX) : (cnt_q == '0));

  always_comb begin
    cnt_nxt = cnt_q;
    per_nxt = per_q;
    if (tick) begin
      if (div_mode) begin
        if (term) begin
          cnt_nxt = load_q;
          per_nxt = load_q;
        end else begin
          cnt_nxt = cnt_q - CNT_ONE;
        end
      end else if (up) begin
        cnt_nxt = cnt_q + CNT_ONE;
      end else begin
        cnt_nxt = cnt_q - CNT_ONE;
      end
    end
  end

  assign sq_hi = cnt_nxt > (per_nxt >> 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      load_q   <= '0;
      per_q    <= '0;
      cnt_q    <= '0;
      shadow_q <= '0;
      sync_q   <= '0;
      out_q    <= 1'b0;
      tc_q     <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-1:0], cnt_in};
      tc_q   <= tick & term;
      if (!en)
        out_q <= 1'b0;
      else if (!square)
        out_q <= tick & term;
      else if (div_mode)
        out_q <= sq_hi;
      else
        out_q <= out_q ^ (tick & term);
      if (wr_ctrl)
        ctrl_q <= bus_wdata[CTRL_W-1:0];
      if (wr_latch)
        shadow_q <= cnt_q;
      if (wr_load) begin
        load_q <= bus_wdata;
      end
      if (wr_load && !en) begin
        cnt_q <= bus_wdata;
        per_q <= bus_wdata;
      end else begin
        cnt_q <= cnt_nxt;
        per_q <= per_nxt;
      end
    end
  end

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = load_q;
      2'd1:    bus_rdata = {{(CNT_W-CTRL_W){1'b0}}, ctrl_q};
      2'd2:    bus_rdata = shadow_q;
      default: bus_rdata = '0;
    endcase
  end

  assign cnt_out = out_q;
  assign tc_evt  = tc_q;
endmodule

module ctr_timer_channel_chk #(
  parameter int CNT_W = 36
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic [1:0]       bus_addr,
  input logic [CNT_W-1:0] bus_wdata,
  input logic             en,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] shadow,
  input logic             cnt_out,
  input logic             tc_evt
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (cnt == '0 && !cnt_out && !tc_evt && !en));

  // R2
  load_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd0 && !en) |=> (cnt == $past(bus_wdata)));

  // R6
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == 2'd2) |=> $stable(shadow));

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && $past(!en)) |-> (!cnt_out && !tc_evt));

  // R12
  idle_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !(bus_wr && bus_addr == 2'd0)) |=> $stable(cnt));

  // R9
  tc_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tc_evt |-> $past(en));
endmodule

bind ctr_timer_channel ctr_timer_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .en(en), .cnt(cnt_q), .shadow(shadow_q),
  .cnt_out(cnt_out), .tc_evt(tc_evt)
);

// File: tb/test_ctr_timer_channel.sv
`timescale 1ns/100ps
module test_ctr_timer_channel;
  localparam int W = 36;
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic         clk = 1'b0;
  logic         rst_n;
  logic         bus_wr;
  logic [1:0]   bus_addr;
  logic [W-1:0] bus_wdata;
  logic [W-1:0] bus_rdata;
  logic         cnt_in;
  logic         cnt_out;
  logic         tc_evt;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    int           kind;
    logic [W-1:0] exp;
    string        req;
  } item_t;
  item_t exp_q[$];

  ctr_timer_channel #(.CNT_W(W)) i_ctr_timer_channel (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_in(cnt_in),
    .cnt_out(cnt_out), .tc_evt(tc_evt)
  );

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      item_t it;
      logic [W-1:0] act;
      it = exp_q.pop_front();
      case (it.kind)
        0:       act = bus_rdata;
        1:       act = W'(cnt_out);
        default: act = W'(tc_evt);
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s kind %0d: actual %0h expected %0h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic push(input int kind, input logic [W-1:0] e, input string req);
    item_t it;
    it.kind = kind;
    it.exp  = e;
    it.req  = req;
    exp_q.push_back(it);
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(posedge clk);
    #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [W-1:0] e, input string req);
    bus_addr = a;
    push(0, e, req);
    @(negedge clk);
    #1;
  endtask

  task automatic latch();
    wr(2'd2, '0);
  endtask

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; cnt_in = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, 0, "R1");
    rd(2'd1, 0, "R1");
    rd(2'd2, 0, "R1");
    push(1, 0, "R1");
    push(2, 0, "R1");
    rd(2'd3, 0, "R13");

    // R2 load while disabled
    wr(2'd0, 100);
    latch();
    rd(2'd2, 100, "R2");

    // R3 up count, internal clock; R6 shadow holds
    wr(2'd1, 3);
    rd(2'd1, 3, "R13");
    step(9);
    latch();
    rd(2'd2, 109, "R3");
    step(5);
    rd(2'd2, 109, "R6");
    latch();
    rd(2'd2, 115, "R6");

    // R4 down count
    wr(2'd1, 0);
    wr(2'd0, 20);
    wr(2'd1, 1);
    step(5);
    latch();
    rd(2'd2, 15, "R4");

    // R4 down wrap, R9 pulse shape
    wr(2'd1, 0);
    wr(2'd0, 3);
    wr(2'd1, 1);
    step(3);
    push(2, 0, "R4");
    step(1);
    push(2, 1, "R4");
    push(1, 1, "R9");
    step(1);
    push(2, 0, "R9");
    push(1, 0, "R9");
    latch();
    rd(2'd2, MAXV - 1, "R4");

    // R3 up wrap, R11 free square toggle
    wr(2'd1, 0);
    wr(2'd0, MAXV - 1);
    wr(2'd1, 19);
    step(1);
    push(1, 0, "R11");
    push(2, 0, "R3");
    step(1);
    push(2, 1, "R3");
    push(1, 1, "R11");
    step(3);
    push(1, 1, "R11");
    push(2, 0, "R3");
    latch();
    rd(2'd2, 3, "R3");

    // R12 disable freezes and quiets
    wr(2'd1, 0);
    step(1);
    push(1, 0, "R12");
    push(2, 0, "R12");
    latch();
    rd(2'd2, 5, "R12");
    step(4);
    latch();
    rd(2'd2, 5, "R12");

    // R5 external source
    wr(2'd0, 0);
    wr(2'd1, 7);
    for (int i = 0; i < 5; i++) begin
      cnt_in = 1'b1;
      step(4);
      cnt_in = 1'b0;
      step(4);
    end
    step(4);
    latch();
    rd(2'd2, 5, "R5");
    step(6);
    latch();
    rd(2'd2, 5, "R5");
    cnt_in = 1'b1;
    step(20);
    cnt_in = 1'b0;
    step(5);
    latch();
    rd(2'd2, 6, "R5");

    // R7 divide by 4, pulse
    wr(2'd1, 0);
    wr(2'd0, 4);
    wr(2'd1, 9);
    step(3);
    push(1, 0, "R7");
    step(1);
    push(1, 1, "R7");
    push(2, 1, "R9");
    step(1);
    push(1, 0, "R7");
    step(3);
    push(1, 1, "R7");

    // R8 load while enabled waits for reload
    wr(2'd0, 6);
    rd(2'd0, 6, "R8");
    step(3);
    push(1, 1, "R8");
    step(5);
    push(1, 0, "R8");
    step(1);
    push(1, 1, "R8");

    // R10 divide by 5, square; up bit set but ignored (R7)
    wr(2'd1, 0);
    wr(2'd0, 5);
    wr(2'd1, 27);
    rd(2'd1, 27, "R13");
    step(5);
    push(1, 1, "R10");
    step(1); push(1, 1, "R10");
    step(1); push(1, 1, "R10");
    step(1); push(1, 0, "R10");
    step(1); push(1, 0, "R10");
    step(1); push(1, 1, "R7");

    step(2);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule